// File: doc/BRIEF.md
# Self-Refresh Exit Command Gate

This block sits between a DRAM command scheduler and the command bus and enforces the waiting times that follow a self-refresh exit. Each cycle the scheduler presents one candidate command. The block sorts it into one of three delay classes: fast, normal or DLL-locked. It then compares the cycles elapsed since the last exit event with that class's programmable threshold. The block raises a grant only when the wait is over.

The three thresholds are inputs. Their order must be fast ≤ normal ≤ DLL. Two mode inputs shape the sorting. One says that per-device addressing is active, which disables fast mode-register access. The other says that the internal write reference generator was powered down during self refresh, which moves plain writes and write leveling to the DLL delay. Once the elapsed count reaches the DLL threshold, the window closes and every command is granted until the next exit event. If the scheduler issues a command that is not yet allowed, a sticky violation flag is set.

Top module: `srx_cmd_gate`

## Requirements
- R1: After reset no exit window is open: any presented command is granted whenever `req_valid` is 1, and `violation` is 0.
- R2: In the cycle where `exit_pulse` is 1, no command is allowed. In the cycle after it, the elapsed count is 1, and it rises by one each cycle after that.
- R3: Command codes 0 to 5 (activate, precharge, precharge-all, refresh, self-refresh entry, power-down entry) are allowed once the elapsed count is ≥ `thr_norm`.
- R4: Command codes 6 and 7 (long and short ZQ calibration) are allowed once the elapsed count is ≥ `thr_fast`.
- R5: Code 8 is a mode-register write. It uses `thr_fast` only when `per_dram` is 0 and `req_field` is below the fast-field count of register `req_mr`. The fast-field counts are: register 0 → 3; registers 2 and 6 → 2; registers 1, 3, 4 and 5 → 1; register 7 → 0. Every other mode-register write uses `thr_norm`.
- R6: Code 9 (a write whose termination is controlled by the write command) uses `thr_dll`.
- R7: Code 10 (a plain first write or write leveling) uses `thr_norm` when `vref_off` is 0 and `thr_dll` when `vref_off` is 1.
- R8: Codes 11 to 15 (reads and any other command) use `thr_dll`.
- R9: When the elapsed count is ≥ `thr_dll`, the window closes. All commands are then allowed until the next `exit_pulse`, which reopens the window.
- R10: If `issue` is 1 in a cycle where the presented command is not allowed, `violation` is 1 from the next cycle and stays 1 until reset.
- R11: `grant` is 1 exactly when `req_valid` is 1 and the presented command is allowed. A request that arrives early is held with `grant` at 0 up to the first cycle where its threshold is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_pulse | input | 1 | Self-refresh exit registered on the bus |
| thr_fast | input | CNT_W | Fast-class delay in cycles |
| thr_norm | input | CNT_W | Normal-class delay in cycles |
| thr_dll | input | CNT_W | DLL-class delay in cycles |
| vref_off | input | 1 | Write reference generator was off in self refresh |
| per_dram | input | 1 | Per-device addressing mode active |
| req_valid | input | 1 | Scheduler presents a command |
| req_kind | input | 4 | Command code (see R3–R8) |
| req_mr | input | MR_W | Mode-register index for code 8 |
| req_field | input | FLD_W | Field-select tag for code 8 |
| issue | input | 1 | Scheduler drives the presented command onto the bus |
| grant | output | 1 | Presented command may be issued now |
| violation | output | 1 | Sticky flag for an early issue |

## Verification
The first patterns are directed sweeps after an exit event. Each holds one command type for several cycles, so the grant edge shows where that class's threshold lies. The thresholds are chosen so that the fast, normal and DLL edges fall in different cycles. Mode-register probes cover fields on both sides of each register's fast-field limit, with per-device mode off and on. Plain writes are run with the reference generator on and off, which tells the R7 normal-versus-DLL choice apart. The bench also issues deliberately early commands to check the sticky flag. It then runs long random runs with random thresholds, kinds, register indexes and modes, with exit events placed at random, including one that lands after the window has closed.

// File: rtl/srxg_pkg.sv
`timescale 1ns/1ps
package srxg_pkg;

   typedef enum logic [1:0] {
      CLS_FAST = 2'd0,
      CLS_NORM = 2'd1,
      CLS_DLL  = 2'd2
   } gate_cls_e;

   localparam logic [3:0] K_ZQ_LONG  = 4'd6;
   localparam logic [3:0] K_ZQ_SHORT = 4'd7;
   localparam logic [3:0] K_MRW      = 4'd8;
   localparam logic [3:0] K_WR_ODT   = 4'd9;
   localparam logic [3:0] K_WR_PLAIN = 4'd10;

   // number of low field tags per mode register that may use the fast delay
   function automatic int unsigned mr_fast_fields(input int unsigned mr);
      case (mr)
         0:       return 3;
         2, 6:    return 2;
         1, 3, 4, 5: return 1;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/srxg_classify.sv
`timescale 1ns/1ps
module srxg_classify
   import srxg_pkg::*;
#(
   parameter int MR_W  = 3,
   parameter int FLD_W = 3
) (
   input  logic [3:0]       kind,
   input  logic [MR_W-1:0]  mr,
   input  logic [FLD_W-1:0] field,
   input  logic             per_dram,
   input  logic             vref_off,
   output gate_cls_e        cls
);
   localparam int NUM_MR = 1 << MR_W;

   initial begin
      assert (MR_W >= 3) else $error("srxg_classify: MR_W must cover eight registers");
      assert (FLD_W >= 2) else $error("srxg_classify: FLD_W must hold three field tags");
   end

   logic [NUM_MR-1:0] fast_hit;

   // one comparator per mode register against its fast-field limit (R5)
   for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
      localparam int unsigned LIM = mr_fast_fields(i);
      assign fast_hit[i] = (32'(field) < LIM);
   end

   logic mrw_fast;
   assign mrw_fast = fast_hit[mr] && !per_dram;

   always_comb begin
      if (kind <= 4'd5)
         cls = CLS_NORM;                         // R3
      else if (kind == K_ZQ_LONG || kind == K_ZQ_SHORT)
         cls = CLS_FAST;                         // R4
      else if (kind == K_MRW)
         cls = mrw_fast ? CLS_FAST : CLS_NORM;   // R5
      else if (kind == K_WR_ODT)
         cls = CLS_DLL;                          // R6
      else if (kind == K_WR_PLAIN)
         cls = vref_off ? CLS_DLL : CLS_NORM;    // R7
      else
         cls = CLS_DLL;                          // R8
   end

endmodule

// File: rtl/srxg_elapsed.sv
`timescale 1ns/1ps
module srxg_elapsed #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exit_pulse,
   input  logic [CNT_W-1:0] thr_dll,
   output logic [CNT_W-1:0] elapsed,
   output logic             free
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial assert (CNT_W >= 2) else $error("srxg_elapsed: CNT_W too small");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= '0;
         free    <= 1'b1;
      end else if (exit_pulse) begin
         elapsed <= CNT_W'(1);
         free    <= 1'b0;
      end else if (!free) begin
         if (elapsed >= thr_dll)
            free <= 1'b1;
         else if (elapsed != CNT_MAX)
            elapsed <= elapsed + 1'b1;
      end
   end

   a_r2_restart_at_one: assert property (@(posedge clk) disable iff (!rst_n)
      exit_pulse |=> (elapsed == CNT_W'(1)) && !free);

   a_r9_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
      free && !exit_pulse |=> free);

   a_r2_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
      !free && !exit_pulse && (elapsed < thr_dll) |=> elapsed == $past(elapsed) + 1'b1);

endmodule

// File: rtl/srxg_thr_sel.sv
`timescale 1ns/1ps
module srxg_thr_sel
   import srxg_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter bit CMP_SHARED = 1'b1
) (
   input  gate_cls_e        cls,
   input  logic [CNT_W-1:0] thr_fast,
   input  logic [CNT_W-1:0] thr_norm,
   input  logic [CNT_W-1:0] thr_dll,
   input  logic [CNT_W-1:0] elapsed,
   input  logic             free,
   input  logic             exit_pulse,
   output logic             allowed
);
   logic reach;

   if (CMP_SHARED) begin : g_shared
      // select the threshold first, then one magnitude comparator
      logic [CNT_W-1:0] thr_sel;
      always_comb begin
         case (cls)
            CLS_FAST: thr_sel = thr_fast;
            CLS_NORM: thr_sel = thr_norm;
            default:  thr_sel = thr_dll;
         endcase
      end
      assign reach = (elapsed >= thr_sel);
   end else begin : g_parallel
      // three comparators in parallel, class picks a single bit
      logic ge_fast, ge_norm, ge_dll;
      assign ge_fast = (elapsed >= thr_fast);
      assign ge_norm = (elapsed >= thr_norm);
      assign ge_dll  = (elapsed >= thr_dll);
      always_comb begin
         case (cls)
            CLS_FAST: reach = ge_fast;
            CLS_NORM: reach = ge_norm;
            default:  reach = ge_dll;
         endcase
      end
   end

   assign allowed = !exit_pulse && (free || reach);

endmodule

// File: rtl/srx_cmd_gate.sv
`timescale 1ns/1ps
module srx_cmd_gate
   import srxg_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int MR_W       = 3,
   parameter int FLD_W      = 3,
   parameter bit CMP_SHARED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exit_pulse,
   input  logic [CNT_W-1:0] thr_fast,
   input  logic [CNT_W-1:0] thr_norm,
   input  logic [CNT_W-1:0] thr_dll,
   input  logic             vref_off,
   input  logic             per_dram,
   input  logic             req_valid,
   input  logic [3:0]       req_kind,
   input  logic [MR_W-1:0]  req_mr,
   input  logic [FLD_W-1:0] req_field,
   input  logic             issue,
   output logic             grant,
   output logic             violation
);
   gate_cls_e        req_cls;
   logic [CNT_W-1:0] elapsed;
   logic             free;
   logic             allowed;

   srxg_classify #(.MR_W(MR_W), .FLD_W(FLD_W)) u_cls (
      .kind     (req_kind),
      .mr       (req_mr),
      .field    (req_field),
      .per_dram (per_dram),
      .vref_off (vref_off),
      .cls      (req_cls)
   );

   srxg_elapsed #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .exit_pulse (exit_pulse),
      .thr_dll    (thr_dll),
      .elapsed    (elapsed),
      .free       (free)
   );

   srxg_thr_sel #(.CNT_W(CNT_W), .CMP_SHARED(CMP_SHARED)) u_sel (
      .cls        (req_cls),
      .thr_fast   (thr_fast),
      .thr_norm   (thr_norm),
      .thr_dll    (thr_dll),
      .elapsed    (elapsed),
      .free       (free),
      .exit_pulse (exit_pulse),
      .allowed    (allowed)
   );

   assign grant = req_valid && allowed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         violation <= 1'b0;
      else if (issue && !allowed)
         violation <= 1'b1;
   end

   a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_valid);

   a_r2_pulse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      exit_pulse |-> !grant);

   a_r3_norm_early_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(exit_pulse) && !exit_pulse && (req_cls == CLS_NORM) && (thr_norm > CNT_W'(1))
      |-> !grant);

   a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      issue && !allowed |=> violation);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

endmodule

// File: tb/sim_srx_cmd_gate.sv
`timescale 1ns/1ps
module sim_srx_cmd_gate;
   localparam int CNT_W = 12;
   localparam int MR_W  = 3;
   localparam int FLD_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             exit_pulse = 1'b0;
   logic [CNT_W-1:0] thr_fast = '0, thr_norm = '0, thr_dll = '0;
   logic             vref_off = 1'b0, per_dram = 1'b0;
   logic             req_valid = 1'b0;
   logic [3:0]       req_kind = '0;
   logic [MR_W-1:0]  req_mr = '0;
   logic [FLD_W-1:0] req_field = '0;
   logic             issue = 1'b0;
   logic             grant, violation;

   always #10 clk = ~clk;   // 50 MHz

   srx_cmd_gate #(.CNT_W(CNT_W), .MR_W(MR_W), .FLD_W(FLD_W)) u0 (
      .clk(clk), .rst_n(rst_n), .exit_pulse(exit_pulse),
      .thr_fast(thr_fast), .thr_norm(thr_norm), .thr_dll(thr_dll),
      .vref_off(vref_off), .per_dram(per_dram), .req_valid(req_valid),
      .req_kind(req_kind), .req_mr(req_mr), .req_field(req_field),
      .issue(issue), .grant(grant), .violation(violation));

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   // bench model of the window
   int  m_cnt  = 0;
   bit  m_free = 1'b1;
   bit  m_viol = 1'b0;

   function automatic int fast_lim(int mr);
      case (mr)
         0: return 3;
         2, 6: return 2;
         1, 3, 4, 5: return 1;
         default: return 0;
      endcase
   endfunction

   // 0 fast, 1 normal, 2 dll
   function automatic int exp_class(int kind, int mr, int fld, bit per, bit vref);
      if (kind <= 5) return 1;
      if (kind == 6 || kind == 7) return 0;
      if (kind == 8) return (!per && fld < fast_lim(mr)) ? 0 : 1;
      if (kind == 9) return 2;
      if (kind == 10) return vref ? 2 : 1;
      return 2;
   endfunction

   function automatic bit exp_allowed(bit pulse, int cls);
      int thr;
      thr = (cls == 0) ? int'(thr_fast) : (cls == 1) ? int'(thr_norm) : int'(thr_dll);
      return !pulse && (m_free || m_cnt >= thr);
   endfunction

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // imode: 0 no issue, 1 force issue, 2 issue only when allowed
   task automatic step(bit pulse, bit valid, int kind, int mr, int fld, int imode, string req);
      bit al;
      bit iss;
      al  = exp_allowed(pulse, exp_class(kind, mr, fld, per_dram, vref_off));
      iss = (imode == 1) || (imode == 2 && al);
      @(negedge clk);
      exit_pulse = pulse; req_valid = valid; req_kind = 4'(kind);
      req_mr = MR_W'(mr); req_field = FLD_W'(fld); issue = iss;
      #2;
      check(req, int'(grant), int'(valid && al));
      check("R10 flag", int'(violation), int'(m_viol));
      @(posedge clk);
      if (iss && !al) m_viol = 1'b1;
      if (pulse) begin
         m_cnt = 1; m_free = 1'b0;
      end else if (!m_free) begin
         if (m_cnt >= int'(thr_dll)) m_free = 1'b1;
         else m_cnt++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; exit_pulse = 1'b0; issue = 1'b0; req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0; m_free = 1'b1; m_viol = 1'b0;
   endtask

   task automatic set_thr(int f, int n, int d);
      @(negedge clk);
      thr_fast = CNT_W'(f); thr_norm = CNT_W'(n); thr_dll = CNT_W'(d);
   endtask

   // pulse, then hold one request for len cycles
   task automatic sweep(int kind, int mr, int fld, int len, string req);
      step(1'b1, 1'b1, kind, mr, fld, 0, "R2 pulse cycle");
      for (int i = 0; i < len; i++) step(1'b0, 1'b1, kind, mr, fld, 0, req);
   endtask

   initial begin
      void'($urandom(32'd2718));
      set_thr(3, 6, 10);
      do_reset();

      // R1: no window after reset
      check("R1 reset violation", int'(violation), 0);
      step(1'b0, 1'b1, 0, 0, 0, 0, "R1 free grant");
      step(1'b0, 1'b1, 9, 0, 0, 0, "R1 free grant dll class");
      step(1'b0, 1'b0, 0, 0, 0, 0, "R11 no request no grant");

      // R3/R11: activate held until elapsed reaches thr_norm
      sweep(0, 0, 0, 12, "R3 normal class edge");
      sweep(5, 0, 0, 8, "R3 power-down entry");
      // R4: ZQ
      sweep(6, 0, 0, 5, "R4 zq long");
      sweep(7, 0, 0, 5, "R4 zq short");
      // R5: mode-register writes on both sides of the limits
      sweep(8, 0, 2, 7, "R5 mr0 last fast field");
      sweep(8, 0, 3, 7, "R5 mr0 slow field");
      sweep(8, 6, 1, 7, "R5 mr6 fast field");
      sweep(8, 2, 2, 7, "R5 mr2 slow field");
      sweep(8, 1, 1, 7, "R5 mr1 slow field");
      sweep(8, 7, 0, 7, "R5 mr7 never fast");
      per_dram = 1'b1;
      sweep(8, 0, 0, 7, "R5 per-device forces normal");
      per_dram = 1'b0;
      // R6, R7, R8
      sweep(9, 0, 0, 12, "R6 odt write dll");
      vref_off = 1'b0;
      sweep(10, 0, 0, 12, "R7 plain write vref on");
      vref_off = 1'b1;
      sweep(10, 0, 0, 12, "R7 plain write vref off");
      vref_off = 1'b0;
      sweep(12, 0, 0, 12, "R8 other command dll");
      // R9: window closes, then reopens on a new pulse
      sweep(11, 0, 0, 16, "R9 saturation");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 15, 0, 0, 0, "R9 free after close");
      sweep(0, 0, 0, 4, "R9 reopened");

      // R10: early issue sets a sticky flag
      step(1'b1, 1'b1, 0, 0, 0, 0, "R2 pulse cycle");
      step(1'b0, 1'b1, 0, 0, 0, 1, "R10 early issue");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, 0, 0, 0, "R10 sticky");
      step(1'b1, 1'b0, 0, 0, 0, 0, "R10 sticky over pulse");
      check("R10 still set", int'(violation), 1);
      do_reset();
      check("R1 flag cleared", int'(violation), 0);

      // random segments
      for (int s = 0; s < 10; s++) begin
         int f, n, d;
         f = $urandom % 6; n = f + $urandom % 6; d = n + $urandom % 12;
         set_thr(f, n, d);
         vref_off = 1'($urandom); per_dram = 1'($urandom % 4 == 0);
         step(1'b1, 1'b0, 0, 0, 0, 0, "R2 segment pulse");
         for (int i = 0; i < 400; i++)
            step(1'($urandom % 40 == 0), 1'($urandom), $urandom % 16, $urandom % 8,
                 $urandom % 8, 2, "R11 random grant");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule